// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps an asynchronous DRAM alive. After reset it waits out the mandatory power-up delay. It then runs a short burst of dummy refresh cycles, and only after that does it raise a flag that lets the access side start issuing reads and writes. From then on, a free-running interval timer produces one refresh obligation per interval. The interval is sized so that the whole array is refreshed evenly within the retention period. The block uses the CAS-before-RAS refresh form, so no address needs to be driven.

The block shares the strobe pins with an access controller. It asks for them with a request line and takes them when the controller answers on a grant line. While it owns the pins, it drives the row strobe, column strobe and write enable itself. Obligations that cannot be served at once are counted, so a few refreshes can be postponed while the controller is busy. When the count reaches its ceiling, an urgent flag is raised. Before dropping the request, the block always hands the pins back with both strobes high.

All delays are counts of clock cycles. At a 4 ns clock the defaults give a 200 µs power-up wait and a 15.6 µs refresh interval. They also give a refresh cycle of 30 clocks: 3 clocks of column-strobe lead, 16 clocks of row-strobe low and 11 clocks of precharge.

Top module: `rfsh_sched`

## Requirements
- R1: Out of reset, `req`, `own`, `init_done` and `urgent` are low and `ras_n`, `cas_n`, `we_n` are high. `req` stays low for exactly `T_PWRUP` clock edges after reset is released and is high after edge `T_PWRUP`.
- R2: Exactly `INIT_CYC` refresh cycles are completed before `init_done` rises, and `init_done` stays low during all of them.
- R3: Each refresh is CAS-before-RAS. `cas_n` goes low exactly `T_CSR` cycles before `ras_n` goes low, and it stays low until `ras_n` rises, in the same cycle as `ras_n`.
- R4: `we_n` is high whenever the row strobe falls or rises.
- R5: `ras_n` is low for exactly `T_RAS` cycles per refresh. Both strobes are high for at least `T_RP` cycles before either falls again.
- R6: After `init_done`, one refresh obligation is added every `T_REFI` cycles, the first one at edge `T_REFI` after `init_done` rises. With the grant always given, consecutive refreshes start exactly `T_REFI` cycles apart.
- R7: `urgent` is high exactly while `MAX_DEBT` obligations are outstanding. The count saturates there, and once granted the block serves at least `MAX_DEBT` refreshes back to back and then clears `urgent`.
- R8: While `grant` is low, no strobe moves and `req` stays high as long as anything is owed.
- R9: `req` falls only in a cycle where `ras_n` and `cas_n` are both high and `own` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Access controller hands over the strobe pins |
| req | output | 1 | Request for the strobe pins |
| own | output | 1 | High while this block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high during refresh |
| init_done | output | 1 | Power-up wait and dummy refresh burst finished |
| urgent | output | 1 | Postponed refresh count at its ceiling |

## Verification
The bench goes after the boundary at the end of power-up. A timer off by one would let the request rise a cycle early or late. It also watches the last dummy refresh, where a design that decremented the wrong counter would raise `init_done` early or leave a stray obligation behind. In the postponement scenario the grant is withheld across more than `MAX_DEBT` intervals. A design that did not saturate, or that fired strobes without a grant, would either lose `urgent` or move `ras_n`. It would also serve the wrong number of back-to-back cycles once released. Every strobe edge is timed against the lead, width and precharge counts, so a swapped phase order or a short precharge shows up as a wrong run length.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CLEAD  = 2'd1,
    ST_ROWLO  = 2'd2,
    ST_PRECH  = 2'd3
  } rf_state_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int T_PWRUP = 50000,
  parameter int T_REFI  = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pwrup_done,
  output logic tick
);
  localparam int PW_W = $clog2(T_PWRUP + 1);
  localparam int IV_W = $clog2(T_REFI + 1);
  localparam logic [PW_W-1:0] PW_LAST = PW_W'(T_PWRUP - 1);
  localparam logic [IV_W-1:0] IV_LAST = IV_W'(T_REFI - 1);

  logic [PW_W-1:0] pw_q;
  logic [IV_W-1:0] iv_q;
  logic            pw_done_q;

  assign pwrup_done = pw_done_q;
  assign tick       = run && (iv_q == IV_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_q      <= '0;
      pw_done_q <= 1'b0;
    end else if (!pw_done_q) begin
      if (pw_q == PW_LAST) pw_done_q <= 1'b1;
      else                 pw_q      <= pw_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      iv_q <= '0;
    else if (run)    iv_q <= (iv_q == IV_LAST) ? '0 : iv_q + 1'b1;
  end

  // R6: an obligation tick is a single-cycle pulse
  a_r6_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_debt.sv
module rfsh_debt #(
  parameter int INIT_CYC = 8,
  parameter int MAX_DEBT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrup_done,
  input  logic tick,
  input  logic done,
  output logic init_done,
  output logic pending,
  output logic urgent
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam int DW = $clog2(MAX_DEBT + 1);
  localparam logic [DW-1:0] D_MAX = DW'(MAX_DEBT);

  logic [IW-1:0] init_q;
  logic [DW-1:0] debt_q;
  logic          in_init;

  function automatic logic [DW-1:0] debt_next(logic [DW-1:0] d, logic inc, logic dec);
    if (inc && !dec && d != D_MAX) return d + 1'b1;
    if (dec && !inc && d != '0)    return d - 1'b1;
    return d;
  endfunction

  assign in_init   = (init_q != '0);
  assign init_done = pwrup_done && !in_init;
  assign pending   = pwrup_done && (in_init || debt_q != '0);
  assign urgent    = (debt_q == D_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= IW'(INIT_CYC);
      debt_q <= '0;
    end else begin
      if (done && in_init) init_q <= init_q - 1'b1;
      debt_q <= debt_next(debt_q, tick, done && !in_init);
    end
  end

  // R2: no obligation can accumulate before the dummy burst ends
  a_r2_no_debt_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> debt_q == '0);
  // R7: urgency is only left by serving a refresh
  a_r7_urgent_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent && !done) |=> urgent);
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int T_CSR = 3,
  parameter int T_RAS = 16,
  parameter int T_RP  = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic grant,
  output logic req,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic done
);
  localparam int LMAX = max3(T_CSR, T_RAS, T_RP);
  localparam int CW   = $clog2(LMAX + 1);

  rf_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          last;

  function automatic logic [CW-1:0] phase_load(rf_state_e s);
    case (s)
      ST_CLEAD: return CW'(T_CSR - 1);
      ST_ROWLO: return CW'(T_RAS - 1);
      ST_PRECH: return CW'(T_RP - 1);
      default:  return '0;
    endcase
  endfunction

  assign last = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (pending && grant) state_d = ST_CLEAD;
      ST_CLEAD: if (last) state_d = ST_ROWLO;
      ST_ROWLO: if (last) state_d = ST_PRECH;
      ST_PRECH: if (last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= phase_load(state_d);
      else if (!last)         cnt_q <= cnt_q - 1'b1;
    end
  end

  assign own   = (state_q != ST_IDLE);
  assign req   = own || pending;
  assign ras_n = (state_q != ST_ROWLO);
  assign cas_n = !((state_q == ST_CLEAD) || (state_q == ST_ROWLO));
  assign we_n  = 1'b1;
  assign done  = (state_q == ST_PRECH) && last;

  // R3: the row strobe only falls with the column strobe already low
  a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ($past(cas_n) == 1'b0));
  // R8: without a grant an idle sequencer stays idle
  a_r8_grant_needed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !grant) |=> state_q == ST_IDLE);
  // R9: the request is dropped only with both strobes released
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req) |-> (ras_n && cas_n && !own));
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int T_PWRUP  = 50000,
  parameter int T_REFI   = 3900,
  parameter int INIT_CYC = 8,
  parameter int MAX_DEBT = 8,
  parameter int T_CSR    = 3,
  parameter int T_RAS    = 16,
  parameter int T_RP     = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic req,
  output logic own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done,
  output logic urgent
);
  logic pwrup_done;
  logic tick;
  logic pending;
  logic done;

  rfsh_timer #(.T_PWRUP(T_PWRUP), .T_REFI(T_REFI)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(init_done),
    .pwrup_done(pwrup_done), .tick(tick));

  rfsh_debt #(.INIT_CYC(INIT_CYC), .MAX_DEBT(MAX_DEBT)) u_debt (
    .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done), .tick(tick),
    .done(done), .init_done(init_done), .pending(pending), .urgent(urgent));

  rfsh_seq #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pending), .grant(grant),
    .req(req), .own(own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .done(done));

  // R1: nothing moves on the pins during the power-up wait
  a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrup_done |-> (ras_n && cas_n && !req));
endmodule

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;
  localparam int T_PWRUP  = 100;
  localparam int T_REFI   = 60;
  localparam int INIT_CYC = 8;
  localparam int MAX_DEBT = 4;
  localparam int T_CSR    = 2;
  localparam int T_RAS    = 15;
  localparam int T_RP     = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] grant_mode = 2'd1;
  logic req, own, ras_n, cas_n, we_n, init_done, urgent;
  logic grant;

  assign grant = (grant_mode == 2'd1) ? req : 1'b0;

  rfsh_sched #(.T_PWRUP(T_PWRUP), .T_REFI(T_REFI), .INIT_CYC(INIT_CYC),
               .MAX_DEBT(MAX_DEBT), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .own(own),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done),
    .urgent(urgent));

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int falls = 0;
  int fall_cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Strobe monitor: run lengths measured at negative edges
  logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;
  int ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1'b1; p_cas = 1'b1; p_req = 1'b0;
      ras_lo = 0; ras_hi = 1000; cas_lo = 0; cas_hi = 1000;
    end else begin
      if (p_ras && !ras_n) begin
        falls++;
        fall_cyc = cyc;
        chk(cas_lo == T_CSR, "R3 column strobe lead", cas_lo, T_CSR);
        chk(ras_hi >= T_RP, "R5 row precharge", ras_hi, T_RP);
        chk(we_n == 1'b1, "R4 write enable at row fall", int'(we_n), 1);
        if (falls <= INIT_CYC)
          chk(init_done == 1'b0, "R2 init flag during burst", int'(init_done), 0);
      end
      if (!p_ras && ras_n) begin
        chk(ras_lo == T_RAS, "R5 row low width", ras_lo, T_RAS);
        chk(cas_n == 1'b1 && cas_lo == T_CSR + T_RAS, "R3 column held through row low",
            cas_lo, T_CSR + T_RAS);
        chk(we_n == 1'b1, "R4 write enable at row rise", int'(we_n), 1);
      end
      if (p_cas && !cas_n)
        chk(cas_hi >= T_RP, "R5 column precharge", cas_hi, T_RP);
      if (p_req && !req)
        chk(ras_n && cas_n && !own, "R9 release with strobes high",
            int'({ras_n, cas_n, own}), 6);
      ras_lo = ras_n ? 0 : ras_lo + 1;
      ras_hi = ras_n ? ras_hi + 1 : 0;
      cas_lo = cas_n ? 0 : cas_lo + 1;
      cas_hi = cas_n ? cas_hi + 1 : 0;
      p_ras = ras_n; p_cas = cas_n; p_req = req;
    end
  end

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(!req && !own && !init_done && !urgent, "R1 reset outputs low",
        int'({req, own, init_done, urgent}), 0);
    chk(ras_n && cas_n && we_n, "R1 reset strobes high", int'({ras_n, cas_n, we_n}), 7);
  endtask

  task automatic t_powerup();
    rst_n = 1'b1;
    repeat (T_PWRUP - 1) @(negedge clk);
    chk(req == 1'b0, "R1 request held off during wait", int'(req), 0);
    chk(ras_n && cas_n, "R1 strobes quiet during wait", int'({ras_n, cas_n}), 3);
    @(negedge clk);
    chk(req == 1'b1, "R1 request at end of wait", int'(req), 1);
  endtask

  task automatic t_init();
    int i;
    for (i = 0; i < 2000 && !init_done; i++) @(negedge clk);
    chk(init_done == 1'b1, "R2 init flag rises", int'(init_done), 1);
    chk(falls == INIT_CYC, "R2 dummy refresh count", falls, INIT_CYC);
    grant_mode = 2'd0;
  endtask

  task automatic t_postpone();
    int f0;
    f0 = falls;
    for (int n = 1; n <= (MAX_DEBT + 2) * T_REFI; n++) begin
      @(negedge clk);
      if (n == T_REFI - 1)
        chk(req == 1'b0, "R6 no obligation before first interval", int'(req), 0);
      if (n == T_REFI)
        chk(req == 1'b1, "R6 obligation at first interval", int'(req), 1);
      if (n == MAX_DEBT * T_REFI - 1)
        chk(urgent == 1'b0, "R7 urgent below ceiling", int'(urgent), 0);
      if (n == MAX_DEBT * T_REFI)
        chk(urgent == 1'b1, "R7 urgent at ceiling", int'(urgent), 1);
    end
    chk(urgent == 1'b1, "R7 urgent kept when saturated", int'(urgent), 1);
    chk(req == 1'b1, "R8 request held while owed", int'(req), 1);
    chk(falls == f0, "R8 no strobe activity without grant", falls - f0, 0);
    chk(ras_n && cas_n && !own, "R8 pins untouched without grant",
        int'({ras_n, cas_n, own}), 6);
  endtask

  task automatic t_drain();
    int f0;
    f0 = falls;
    grant_mode = 2'd1;
    for (int i = 0; i < 5000 && (req || falls == f0); i++) @(negedge clk);
    chk(req == 1'b0, "R7 backlog drained", int'(req), 0);
    chk(falls - f0 >= MAX_DEBT, "R7 back-to-back refresh count", falls - f0, MAX_DEBT);
    chk(urgent == 1'b0, "R7 urgent cleared", int'(urgent), 0);
  endtask

  task automatic t_interval();
    int f0, c1;
    f0 = falls;
    for (int i = 0; i < 500 && falls == f0; i++) @(negedge clk);
    c1 = fall_cyc;
    f0 = falls;
    for (int i = 0; i < 500 && falls == f0; i++) @(negedge clk);
    chk(fall_cyc - c1 == T_REFI, "R6 steady refresh spacing", fall_cyc - c1, T_REFI);
    c1 = fall_cyc;
    f0 = falls;
    for (int i = 0; i < 500 && falls == f0; i++) @(negedge clk);
    chk(fall_cyc - c1 == T_REFI, "R6 steady refresh spacing repeat", fall_cyc - c1, T_REFI);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_init();
    t_postpone();
    t_drain();
    t_interval();
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule